// File: doc/BRIEF.md
# Receive Stream Ring Channel

This block is a single streaming receive channel. It watches a receive FIFO that carries address words and data words. After an address word equal to its listen address, it writes each following data word into a circular region of shared memory through a write master that honours a wait request. Once the last slot of the region is written, the write pointer goes back to the region start.

Software sets up the channel with one initialize strobe. The strobe latches a memory start address, a region length in words and a listen address. After that, the channel tracks how many stored words software has not yet consumed. When every slot holds unconsumed data, the channel stops taking data words from the receive FIFO. Software then reports the number of words it has consumed on the acknowledge input, which frees that space and lets reception continue. A sticky interrupt flags newly stored data. A readback port gives the number of words stored since initialization.

Top module: `rsr_channel`

## Requirements
- R1: After reset the channel is inactive: `rx_re_o`, `mem_we_o` and `irq_o` are 0 and `rx_count_o` is 0. No receive word is consumed until the first `init_i` pulse.
- R2: `cfg_base_i`, `cfg_len_i` and `cfg_listen_i` are sampled only in a cycle with `init_i` high. Changing them at any other time has no effect on addresses, capacity or matching. Each init restarts the write offset at the start address.
- R3: A receive word with `rx_av_i`=1 is an address word. If its low `ADDR_W` bits equal the listen address, the data words (`rx_av_i`=0) that follow are written to memory in arrival order, with `mem_data_o` equal to the received word. A data word is popped in the same cycle that the memory accepts its write.
- R4: While `mem_wait_i` is high, `mem_we_o` stays asserted with `mem_addr_o` unchanged, and the pending receive word is not popped.
- R5: The n-th stored word after init (n from 0) goes to address start + (n mod length).
- R6: When the number of unconsumed words equals the region length, no data word is written or popped. Address words are still consumed.
- R7: An acknowledge of k words (`ack_valid_i` high for one cycle while active) lowers the unconsumed count by k, so up to k further words are accepted.
- R8: An acknowledge larger than the unconsumed count sets that count to 0 and never wraps it.
- R9: `rx_count_o` equals the number of words stored since the last init, modulo 2^`WORDS_W`. Init clears it.
- R10: `irq_o` goes to 1 in the cycle after a word is stored. It stays 1 until a cycle with `irq_clr_i`=1 and no store. A store in the same cycle as a clear keeps it at 1.
- R11: Data words that follow an address word not equal to the listen address are popped and discarded. They cause no memory write and do not change `rx_count_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| init_i | input | 1 | Initialize strobe, latches configuration |
| cfg_base_i | input | ADDR_W | Region start address |
| cfg_len_i | input | WORDS_W | Region length in words |
| cfg_listen_i | input | ADDR_W | Receive address to accept |
| ack_valid_i | input | 1 | Consumption acknowledge strobe |
| ack_words_i | input | WORDS_W | Number of words consumed |
| irq_clr_i | input | 1 | Clear the interrupt flag |
| rx_data_i | input | DATA_W | Receive FIFO head word |
| rx_av_i | input | 1 | Head word is an address |
| rx_empty_i | input | 1 | Receive FIFO empty |
| rx_re_o | output | 1 | Pop receive FIFO head |
| mem_addr_o | output | ADDR_W | Memory write address |
| mem_we_o | output | 1 | Memory write request |
| mem_data_o | output | DATA_W | Memory write data |
| mem_wait_i | input | 1 | Memory stalls the write |
| irq_o | output | 1 | Sticky new-data interrupt |
| rx_count_o | output | WORDS_W | Words stored since init |

## Verification
A wrong write offset shows up on `mem_addr_o` at the next stored word. A wrap fault appears on the first word after a full lap, which is the (length+1)-th store. A wrong unconsumed count shows as a stall at the wrong moment: the FIFO keeps words it should have popped, or the channel writes past the length limit before software acknowledges. A faulty clamp shows up only after an acknowledge larger than the count, when the next lap stalls early or never stalls. A lost match flag either drops data addressed to the channel or writes data meant for another address, and this is seen on the first data word after the address word.

// File: rtl/rsr_pkg.sv
`timescale 1ns/1ps
package rsr_pkg;
  typedef enum logic {
    CH_IDLE = 1'b0,
    CH_RUN  = 1'b1
  } ch_state_e;
endpackage

// File: rtl/rsr_ring.sv
`timescale 1ns/1ps
module rsr_ring #(
  parameter int ADDR_W  = 16,
  parameter int WORDS_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               init_i,
  input  logic [ADDR_W-1:0]  cfg_base_i,
  input  logic [WORDS_W-1:0] cfg_len_i,
  input  logic               store_i,
  input  logic               ack_valid_i,
  input  logic [WORDS_W-1:0] ack_words_i,
  output logic               active_o,
  output logic               room_o,
  output logic [ADDR_W-1:0]  mem_addr_o,
  output logic [WORDS_W-1:0] rx_count_o
);
  import rsr_pkg::*;

  localparam logic [WORDS_W-1:0] ONE = WORDS_W'(1);

  ch_state_e          state_q;
  logic [ADDR_W-1:0]  base_q;
  logic [WORDS_W-1:0] len_q, off_q, occ_q, cnt_q;
  logic [WORDS_W-1:0] off_nxt, occ_add, ack_eff, occ_nxt;
  logic               active, last_slot;

  assign active    = (state_q == CH_RUN);
  assign last_slot = (off_q == len_q - ONE);
  assign off_nxt   = last_slot ? '0 : off_q + ONE;

  // store reserves first, then the acknowledge is clamped at zero
  assign occ_add = occ_q + (store_i ? ONE : '0);
  assign ack_eff = (active && ack_valid_i) ? ack_words_i : '0;
  assign occ_nxt = (ack_eff >= occ_add) ? '0 : occ_add - ack_eff;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= CH_IDLE;
      base_q  <= '0;
      len_q   <= '0;
      off_q   <= '0;
      occ_q   <= '0;
      cnt_q   <= '0;
    end else if (init_i) begin
      state_q <= CH_RUN;
      base_q  <= cfg_base_i;
      len_q   <= cfg_len_i;
      off_q   <= '0;
      occ_q   <= '0;
      cnt_q   <= '0;
    end else if (active) begin
      occ_q <= occ_nxt;
      if (store_i) begin
        off_q <= off_nxt;
        cnt_q <= cnt_q + ONE;
      end
    end
  end

  assign active_o   = active;
  assign room_o     = active && (occ_q != len_q);
  assign mem_addr_o = base_q + ADDR_W'(off_q);
  assign rx_count_o = cnt_q;

  assert_full_no_store_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (occ_q == len_q) |-> !store_i);
  assert_occ_bounded_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    occ_q <= len_q);
  assert_off_in_region_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active && len_q != '0) |-> (off_q < len_q));
  assert_count_step_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (store_i && !init_i) |=> (cnt_q == $past(cnt_q) + ONE));
endmodule

// File: rtl/rsr_front.sv
`timescale 1ns/1ps
module rsr_front #(
  parameter int ADDR_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              init_i,
  input  logic [ADDR_W-1:0] cfg_listen_i,
  input  logic              active_i,
  input  logic              room_i,
  input  logic [ADDR_W-1:0] rx_addr_i,
  input  logic              rx_av_i,
  input  logic              rx_empty_i,
  input  logic              mem_wait_i,
  output logic              rx_re_o,
  output logic              mem_we_o,
  output logic              store_o
);
  logic [ADDR_W-1:0] listen_q;
  logic              sel_q;
  logic              head_ok, data_here;

  assign head_ok   = active_i && !rx_empty_i;
  assign data_here = head_ok && !rx_av_i;
  assign mem_we_o  = data_here && sel_q && room_i;
  assign store_o   = mem_we_o && !mem_wait_i;
  // address words always pop; unselected data drops; selected data pops on accept
  assign rx_re_o   = head_ok && (rx_av_i || !sel_q || store_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      listen_q <= '0;
      sel_q    <= 1'b0;
    end else if (init_i) begin
      listen_q <= cfg_listen_i;
      sel_q    <= 1'b0;
    end else if (rx_re_o && rx_av_i) begin
      sel_q <= (rx_addr_i == listen_q);
    end
  end

  assert_idle_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_i |-> (!rx_re_o && !mem_we_o));
  assert_drop_no_write_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_re_o && !rx_av_i && !sel_q) |-> !mem_we_o);
endmodule

// File: rtl/rsr_irq.sv
`timescale 1ns/1ps
module rsr_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic irq_o
);
  logic irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     irq_q <= 1'b0;
    else if (set_i)  irq_q <= 1'b1;
    else if (clr_i)  irq_q <= 1'b0;
  end

  assign irq_o = irq_q;

  assert_clear_only_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_q && !clr_i) |=> irq_q);
endmodule

// File: rtl/rsr_channel.sv
`timescale 1ns/1ps
module rsr_channel #(
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 16,
  parameter int WORDS_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               init_i,
  input  logic [ADDR_W-1:0]  cfg_base_i,
  input  logic [WORDS_W-1:0] cfg_len_i,
  input  logic [ADDR_W-1:0]  cfg_listen_i,
  input  logic               ack_valid_i,
  input  logic [WORDS_W-1:0] ack_words_i,
  input  logic               irq_clr_i,
  input  logic [DATA_W-1:0]  rx_data_i,
  input  logic               rx_av_i,
  input  logic               rx_empty_i,
  output logic               rx_re_o,
  output logic [ADDR_W-1:0]  mem_addr_o,
  output logic               mem_we_o,
  output logic [DATA_W-1:0]  mem_data_o,
  input  logic               mem_wait_i,
  output logic               irq_o,
  output logic [WORDS_W-1:0] rx_count_o
);
  logic active, room, store;

  rsr_ring #(.ADDR_W(ADDR_W), .WORDS_W(WORDS_W)) ring_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .init_i      (init_i),
    .cfg_base_i  (cfg_base_i),
    .cfg_len_i   (cfg_len_i),
    .store_i     (store),
    .ack_valid_i (ack_valid_i),
    .ack_words_i (ack_words_i),
    .active_o    (active),
    .room_o      (room),
    .mem_addr_o  (mem_addr_o),
    .rx_count_o  (rx_count_o)
  );

  rsr_front #(.ADDR_W(ADDR_W)) front_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .init_i       (init_i),
    .cfg_listen_i (cfg_listen_i),
    .active_i     (active),
    .room_i       (room),
    .rx_addr_i    (rx_data_i[ADDR_W-1:0]),
    .rx_av_i      (rx_av_i),
    .rx_empty_i   (rx_empty_i),
    .mem_wait_i   (mem_wait_i),
    .rx_re_o      (rx_re_o),
    .mem_we_o     (mem_we_o),
    .store_o      (store)
  );

  rsr_irq irq_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (store),
    .clr_i  (irq_clr_i),
    .irq_o  (irq_o)
  );

  assign mem_data_o = rx_data_i;

  assert_wait_holds_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && mem_wait_i && !init_i) |=> $stable(mem_addr_o));
  assert_wait_no_pop_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && mem_wait_i) |-> !rx_re_o);
  assert_store_flags_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && !mem_wait_i && !init_i) |=> irq_o);
endmodule

// File: tb/rsr_channel_tb_top.sv
`timescale 1ns/1ps
module rsr_channel_tb_top;
  localparam int DW = 32;
  localparam int AW = 16;
  localparam int WW = 8;

  logic          clk = 1'b0;
  logic          rst_ni;
  logic          init_i, ack_valid_i, irq_clr_i;
  logic [AW-1:0] cfg_base_i, cfg_listen_i;
  logic [WW-1:0] cfg_len_i, ack_words_i;
  logic [DW-1:0] rx_data_i;
  logic          rx_av_i, rx_empty_i, rx_re_o;
  logic [AW-1:0] mem_addr_o;
  logic          mem_we_o, mem_wait_i, irq_o;
  logic [DW-1:0] mem_data_o;
  logic [WW-1:0] rx_count_o;

  always #2.5 clk = ~clk;

  rsr_channel #(.DATA_W(DW), .ADDR_W(AW), .WORDS_W(WW)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .init_i(init_i),
    .cfg_base_i(cfg_base_i), .cfg_len_i(cfg_len_i), .cfg_listen_i(cfg_listen_i),
    .ack_valid_i(ack_valid_i), .ack_words_i(ack_words_i), .irq_clr_i(irq_clr_i),
    .rx_data_i(rx_data_i), .rx_av_i(rx_av_i), .rx_empty_i(rx_empty_i),
    .rx_re_o(rx_re_o), .mem_addr_o(mem_addr_o), .mem_we_o(mem_we_o),
    .mem_data_o(mem_data_o), .mem_wait_i(mem_wait_i), .irq_o(irq_o),
    .rx_count_o(rx_count_o)
  );

  int checks = 0;
  int fails  = 0;

  logic [DW:0]      src_q[$];
  logic [AW+DW-1:0] exp_q[$];
  logic             re_s = 1'b0;

  logic [AW-1:0] m_base, m_listen;
  logic [WW-1:0] m_len, m_off;
  bit            m_sel;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic src_refresh();
    if (src_q.size() == 0) begin
      rx_empty_i = 1'b1; rx_av_i = 1'b0; rx_data_i = '0;
    end else begin
      rx_empty_i = 1'b0; {rx_av_i, rx_data_i} = src_q[0];
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic push_addr(input logic [AW-1:0] a);
    src_q.push_back({1'b1, DW'(a)});
    m_sel = (a == m_listen);
    src_refresh();
  endtask

  // scoreboard driver: expected address per R5, only for selected data (R3/R11)
  task automatic push_data(input logic [DW-1:0] d);
    src_q.push_back({1'b0, d});
    if (m_sel) begin
      exp_q.push_back({m_base + AW'(m_off), d});
      m_off = (m_off + 1'b1 == m_len) ? '0 : m_off + 1'b1;
    end
    src_refresh();
  endtask

  task automatic do_init(input logic [AW-1:0] b, input logic [WW-1:0] l, input logic [AW-1:0] li);
    tick();
    cfg_base_i = b; cfg_len_i = l; cfg_listen_i = li; init_i = 1'b1;
    m_base = b; m_len = l; m_listen = li; m_off = '0; m_sel = 1'b0;
    tick();
    init_i = 1'b0;
  endtask

  task automatic ack(input logic [WW-1:0] k);
    tick();
    ack_valid_i = 1'b1; ack_words_i = k;
    tick();
    ack_valid_i = 1'b0; ack_words_i = '0;
  endtask

  task automatic settle();
    repeat (12) tick();
    @(negedge clk);
  endtask

  // source model: pop the head on an edge where the design asserted read
  always @(posedge clk) begin
    #1;
    if (re_s && src_q.size() != 0) begin
      void'(src_q.pop_front());
      src_refresh();
    end
  end

  // monitor: accepted writes are compared against the scoreboard queue
  always @(negedge clk) begin
    re_s = rx_re_o;
    if (rst_ni && mem_we_o && !mem_wait_i) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R11 unexpected write", 32'(mem_addr_o), 32'hFFFF_FFFF);
      end else begin
        logic [AW+DW-1:0] e;
        e = exp_q.pop_front();
        check(mem_addr_o == e[AW+DW-1:DW], "R3/R5 write address", 32'(mem_addr_o), 32'(e[AW+DW-1:DW]));
        check(mem_data_o == e[DW-1:0], "R3 write data", mem_data_o, e[DW-1:0]);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 20000, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [AW-1:0] held;
    rst_ni = 1'b0; init_i = 1'b0; ack_valid_i = 1'b0; irq_clr_i = 1'b0;
    cfg_base_i = '0; cfg_len_i = '0; cfg_listen_i = '0; ack_words_i = '0;
    mem_wait_i = 1'b0;
    m_base = '0; m_len = '0; m_listen = 16'hFFFF; m_off = '0; m_sel = 1'b0;
    src_refresh();
    push_addr(16'h0099);
    repeat (3) tick();
    rst_ni = 1'b1;
    @(negedge clk);
    check(rx_re_o == 1'b0, "R1 rx_re_o", 32'(rx_re_o), 0);
    check(mem_we_o == 1'b0, "R1 mem_we_o", 32'(mem_we_o), 0);
    check(irq_o == 1'b0, "R1 irq_o", 32'(irq_o), 0);
    check(rx_count_o == '0, "R1 rx_count_o", 32'(rx_count_o), 0);
    repeat (3) tick();
    @(negedge clk);
    check(src_q.size() == 1, "R1 nothing popped before init", src_q.size(), 1);

    do_init(16'h0100, 8'd4, 16'h0040);
    settle();
    check(src_q.size() == 0, "R11 foreign address word consumed", src_q.size(), 0);

    tick();
    push_addr(16'h0040); push_data(32'hA1); push_data(32'hA2);
    settle();
    check(rx_count_o == 8'd2, "R9 count after two", 32'(rx_count_o), 2);
    check(irq_o == 1'b1, "R10 irq set", 32'(irq_o), 1);

    // R2: config changes without init have no effect
    tick();
    cfg_base_i = 16'h0700; cfg_len_i = 8'd2; cfg_listen_i = 16'h0055;
    push_data(32'hA3);
    settle();
    check(rx_count_o == 8'd3, "R2 count after unlatched config", 32'(rx_count_o), 3);

    tick(); irq_clr_i = 1'b1;
    tick(); irq_clr_i = 1'b0;
    @(negedge clk);
    check(irq_o == 1'b0, "R10 irq cleared", 32'(irq_o), 0);

    // R6: fill ring, excess stalls; R5 wrap covered by scoreboard
    tick();
    push_data(32'hA4); push_data(32'hA5); push_data(32'hA6);
    settle();
    check(mem_we_o == 1'b0, "R6 full no write", 32'(mem_we_o), 0);
    check(rx_re_o == 1'b0, "R6 full no pop", 32'(rx_re_o), 0);
    check(src_q.size() == 2, "R6 words held", src_q.size(), 2);
    check(rx_count_o == 8'd4, "R6 count at full", 32'(rx_count_o), 4);

    ack(8'd1);
    settle();
    check(src_q.size() == 1, "R7 one slot freed", src_q.size(), 1);
    check(rx_count_o == 8'd5, "R7 count", 32'(rx_count_o), 5);

    ack(8'd9);
    settle();
    check(src_q.size() == 0, "R8 clamped ack drains", src_q.size(), 0);
    tick();
    push_data(32'hA7); push_data(32'hA8); push_data(32'hA9); push_data(32'hAA);
    settle();
    check(src_q.size() == 1, "R8 occupancy zero not wrapped", src_q.size(), 1);
    check(rx_count_o == 8'd9, "R8 count", 32'(rx_count_o), 9);
    ack(8'd4);
    settle();
    check(rx_count_o == 8'd10, "R7 count after ack", 32'(rx_count_o), 10);

    // R4: wait request holds the write
    tick();
    mem_wait_i = 1'b1;
    push_data(32'hAB);
    @(negedge clk);
    held = mem_addr_o;
    repeat (3) begin
      tick();
      @(negedge clk);
      check(mem_we_o == 1'b1, "R4 write held", 32'(mem_we_o), 1);
      check(rx_re_o == 1'b0, "R4 no pop under wait", 32'(rx_re_o), 0);
      check(mem_addr_o == held, "R4 address stable", 32'(mem_addr_o), 32'(held));
    end
    tick();
    mem_wait_i = 1'b0;
    settle();
    check(rx_count_o == 8'd11, "R4 stored after release", 32'(rx_count_o), 11);

    // R11: foreign address, data dropped
    tick();
    push_addr(16'h0041); push_data(32'hB1); push_data(32'hB2);
    settle();
    check(src_q.size() == 0, "R11 dropped words popped", src_q.size(), 0);
    check(rx_count_o == 8'd11, "R11 count unchanged", 32'(rx_count_o), 11);
    tick();
    push_addr(16'h0040); push_data(32'hC1);
    settle();
    check(rx_count_o == 8'd12, "R3 reselect", 32'(rx_count_o), 12);

    // R2/R9: re-init takes new config and clears count
    do_init(16'h0200, 8'd3, 16'h0041);
    @(negedge clk);
    check(rx_count_o == '0, "R9 init clears count", 32'(rx_count_o), 0);
    tick();
    push_addr(16'h0041); push_data(32'hD1);
    settle();
    check(rx_count_o == 8'd1, "R2 new config count", 32'(rx_count_o), 1);
    check(exp_q.size() == 0, "R3 all expected writes seen", exp_q.size(), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule